// File: doc/BRIEF.md
# OSD Register Access Port over I2C

This block is a slave on a two-wire serial bus (I2C, standard mode) that turns a stream of row, column and data bytes into single-cycle writes on a register port, and that returns one byte from that port when the host reads. The register space is organised as up to 16 rows by up to 31 columns and is split into two banks. The leading bits of each row byte select the bank.

A host may mix three addressing styles within one transfer. Each data byte can be preceded by a full row and column pair. It can be preceded by a column alone, which keeps the current row. Or the host can open a burst, in which every later byte is data and the column steps up by one after each byte. A burst lasts until the next START or STOP. Both bus lines are brought into the system clock domain through synchroniser flops, and the block pulls SDA low only through an open-drain enable. A read is made by first writing a row and a column, then issuing a repeated START with the read address. The block then shifts out the byte that the storage presents for the current pointer.

Top module: `osd_i2c_regport`

## Requirements
- R1: The block acknowledges, by holding SDA low during the ninth SCL pulse, an address byte whose upper seven bits are 0111101: 0x7A selects write and 0x7B selects read. In write mode every following data byte is acknowledged the same way.
- R2: After an address byte with any other value, SDA is not pulled low and no write is issued until the next START.
- R3: A byte whose bits 7..6 are 10 is a row byte. Bit 5 selects the bank (0 for prefix 100, 1 for prefix 101) and bits 3..0 give the row. Where a row or column is expected, a byte with bits 7..6 equal to 11 is ignored and the pointer is kept.
- R4: A byte with bit 7 clear, where a column may appear, is a column byte. Bits 4..0 give the column, and bit 5 set opens a burst.
- R5: A repeated sequence of row, column and data (bursts off) writes each data byte to the bank, row and column given just before it.
- R6: After a data byte outside a burst, a column byte alone sets a new column and keeps the row and bank.
- R7: In a burst, every byte is written as data, even one shaped like a row byte. The column advances by one after each byte and wraps from NUM_COLS-1 to 0.
- R8: Each data byte produces exactly one wr_en pulse, one clock long, issued after its acknowledge bit.
- R9: In a read transfer (row and column written, repeated START, 0x7B) the block acknowledges the address. It then shifts rd_data for the current pointer out MSB first, and rd_bank, rd_row and rd_col show that pointer.
- R10: After reset and after a STOP, SDA is released and wr_en is low.
- R11: A START ends any burst, so the next transfer again expects a row byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| wr_en | output | 1 | One-clock write strobe |
| wr_bank | output | 1 | Bank of the write |
| wr_row | output | ROW_W | Row of the write |
| wr_col | output | COL_W | Column of the write |
| wr_data | output | 8 | Data of the write |
| rd_bank | output | 1 | Bank of the current pointer |
| rd_row | output | ROW_W | Row of the current pointer |
| rd_col | output | COL_W | Column of the current pointer |
| rd_data | input | 8 | Register content at the current pointer |

## Verification
The assertions assume that SCL stays at each level for many system clocks, so that a synchronised SCL edge is never followed by its opposite edge within a cycle or two. They also assume that the host changes SDA only while SCL is low, except to form START and STOP. The bench bus model holds each SCL phase for 40 clocks and changes its SDA drive only in the low phase. The data line is modelled as a wired AND of the host's pull-down and sda_oe. Under these conditions, the open-drain enable rising only while SCL is low and the one-way burst mode are properties of the block, not of the stimulus.

// File: rtl/osd_i2c_pkg.sv
package osd_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam logic [6:0] DEV_ADDR = 7'b0111101;

  typedef enum logic [2:0] {
    LK_IDLE, LK_RX, LK_ACK, LK_TX, LK_MACK
  } link_st_t;

  typedef enum logic [2:0] {
    DC_ROW, DC_COL, DC_DATA, DC_ANY, DC_BURST
  } dec_st_t;
endpackage

// File: rtl/osd_i2c_sync.sv
module osd_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_prev;
  assign scl_fall = ~scl_s & scl_prev;
  assign start_p  = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_p   = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/osd_i2c_link.sv
module osd_i2c_link
  import osd_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  link_st_t          st;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg, txreg;
  logic              addr_ph, rw;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= LK_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txreg    <= '0;
      addr_ph  <= 1'b0;
      rw       <= 1'b0;
      sda_oe   <= 1'b0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (start_p) begin
        st      <= LK_RX;
        bitcnt  <= '0;
        addr_ph <= 1'b1;
        sda_oe  <= 1'b0;
      end else if (stop_p) begin
        st     <= LK_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          LK_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + CNT_W'(1);
            end else if (scl_fall && bitcnt == CNT_W'(BYTE_W)) begin
              if (!addr_ph || shreg[BYTE_W-1:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                st     <= LK_ACK;
                if (addr_ph) rw <= shreg[0];
              end else begin
                st <= LK_IDLE;
              end
            end
          end
          LK_ACK: begin
            if (scl_fall) begin
              addr_ph <= 1'b0;
              if (addr_ph && rw) begin
                txreg  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                bitcnt <= CNT_W'(1);
                st     <= LK_TX;
              end else begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                st     <= LK_RX;
                if (!addr_ph) begin
                  byte_vld <= 1'b1;
                  byte_q   <= shreg;
                end
              end
            end
          end
          LK_TX: begin
            if (scl_fall) begin
              if (bitcnt == CNT_W'(BYTE_W)) begin
                sda_oe <= 1'b0;
                st     <= LK_MACK;
              end else begin
                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~txreg[BYTE_W-2];
                bitcnt <= bitcnt + CNT_W'(1);
              end
            end
          end
          LK_MACK: if (scl_rise) st <= LK_IDLE;
          default: ;
        endcase
      end
    end
  end

  // R1
  oe_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_p && !start_p |=> !sda_oe);
endmodule

// File: rtl/osd_i2c_decode.sv
module osd_i2c_decode
  import osd_i2c_pkg::*;
#(
  parameter int ROW_W    = 4,
  parameter int NUM_COLS = 31,
  parameter int COL_W    = $clog2(NUM_COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_p,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_q,
  output logic              wr_en,
  output logic              wr_bank,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [BYTE_W-1:0] wr_data,
  output logic              ptr_bank,
  output logic [ROW_W-1:0]  ptr_row,
  output logic [COL_W-1:0]  ptr_col
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

  dec_st_t st;
  logic    burst;
  logic    is_row, is_col;
  logic [COL_W-1:0] col_next;

  assign is_row   = byte_q[7:6] == 2'b10;
  assign is_col   = !byte_q[7];
  assign col_next = (ptr_col == COL_LAST) ? '0 : ptr_col + COL_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= DC_ROW;
      burst    <= 1'b0;
      ptr_bank <= 1'b0;
      ptr_row  <= '0;
      ptr_col  <= '0;
      wr_en    <= 1'b0;
      wr_bank  <= 1'b0;
      wr_row   <= '0;
      wr_col   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_p) begin
        st    <= DC_ROW;
        burst <= 1'b0;
      end else if (byte_vld) begin
        case (st)
          DC_ROW, DC_COL, DC_ANY: begin
            if (is_row && st != DC_COL) begin
              ptr_bank <= byte_q[5];
              ptr_row  <= byte_q[ROW_W-1:0];
              st       <= DC_COL;
            end else if (is_col && st != DC_ROW) begin
              ptr_col <= byte_q[COL_W-1:0];
              burst   <= byte_q[5];
              st      <= DC_DATA;
            end
          end
          DC_DATA, DC_BURST: begin
            wr_en   <= 1'b1;
            wr_bank <= ptr_bank;
            wr_row  <= ptr_row;
            wr_col  <= ptr_col;
            wr_data <= byte_q;
            if (burst) begin
              ptr_col <= col_next;
              st      <= DC_BURST;
            end else begin
              st <= DC_ANY;
            end
          end
          default: st <= DC_ROW;
        endcase
      end
    end
  end

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R5
  strobe_source_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(st) == DC_DATA || $past(st) == DC_BURST));

  // R7
  burst_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (st == DC_BURST && !start_p) |=> st == DC_BURST);

  // R11
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    start_p |=> st == DC_ROW);
endmodule

// File: rtl/osd_i2c_regport.sv
module osd_i2c_regport #(
  parameter int ROW_W       = 4,
  parameter int NUM_COLS    = 31,
  parameter int COL_W       = $clog2(NUM_COLS),
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic             wr_en,
  output logic             wr_bank,
  output logic [ROW_W-1:0] wr_row,
  output logic [COL_W-1:0] wr_col,
  output logic [7:0]       wr_data,
  output logic             rd_bank,
  output logic [ROW_W-1:0] rd_row,
  output logic [COL_W-1:0] rd_col,
  input  logic [7:0]       rd_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic byte_vld;
  logic [7:0] byte_q;

  osd_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  osd_i2c_link u_link (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
    .rd_data(rd_data), .sda_oe(sda_oe), .byte_vld(byte_vld), .byte_q(byte_q)
  );

  osd_i2c_decode #(.ROW_W(ROW_W), .NUM_COLS(NUM_COLS), .COL_W(COL_W)) u_dec (
    .clk(clk), .rst(rst), .start_p(start_p), .byte_vld(byte_vld), .byte_q(byte_q),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .ptr_bank(rd_bank), .ptr_row(rd_row), .ptr_col(rd_col)
  );
endmodule

// File: tb/test_osd_i2c_regport.sv
module test_osd_i2c_regport;
  localparam int HALF = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1;
  logic m_low = 1'b0;
  logic sda_line;
  logic sda_oe, wr_en, wr_bank, rd_bank;
  logic [3:0] wr_row, rd_row;
  logic [4:0] wr_col, rd_col;
  logic [7:0] wr_data, rd_data;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int log_n = 0;
  logic [17:0] log_w [64];

  always #5 clk = ~clk;

  assign sda_line = !(m_low || sda_oe);

  function automatic logic [7:0] mem_val(logic b, logic [3:0] r, logic [4:0] c);
    return {b, r[2:0], c[3:0]} ^ 8'h3C;
  endfunction
  assign rd_data = mem_val(rd_bank, rd_row, rd_col);

  osd_i2c_regport i_osd_i2c_regport (
    .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .rd_bank(rd_bank), .rd_row(rd_row), .rd_col(rd_col),
    .rd_data(rd_data)
  );

  always @(negedge clk) begin
    if (wr_en && log_n < 64) begin
      log_w[log_n] <= {wr_bank, wr_row, wr_col, wr_data};
      log_n <= log_n + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wt(HALF / 2);
    scl_drv = 1'b1; wt(HALF);
    m_low = 1'b1; wt(HALF);
    scl_drv = 1'b0; wt(HALF / 2);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wt(HALF / 2);
    scl_drv = 1'b1; wt(HALF);
    m_low = 1'b0; wt(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wt(HALF / 2);
      scl_drv = 1'b1; wt(HALF);
      scl_drv = 1'b0; wt(HALF / 2);
    end
    m_low = 1'b0; wt(HALF / 2);
    scl_drv = 1'b1; wt(HALF / 2);
    ack = ~sda_line; wt(HALF / 2);
    scl_drv = 1'b0; wt(HALF / 2);
  endtask

  task automatic read_byte(output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wt(HALF / 2);
      scl_drv = 1'b1; wt(HALF / 2);
      b[i] = sda_line; wt(HALF / 2);
      scl_drv = 1'b0; wt(HALF / 2);
    end
    wt(HALF / 2);
    scl_drv = 1'b1; wt(HALF);
    scl_drv = 1'b0; wt(HALF / 2);
  endtask

  task automatic send_list(input string req, input logic [7:0] bytes[$]);
    logic ack;
    foreach (bytes[k]) begin
      send_byte(bytes[k], ack);
      check(req, ack, 1);
    end
  endtask

  task automatic expect_wr(input string req, input int idx, input logic b,
                           input logic [3:0] r, input logic [4:0] c, input logic [7:0] d);
    check(req, log_w[idx], {b, r, c, d});
  endtask

  task automatic t_reset();
    check("R10 reset sda", sda_oe, 0);
    check("R10 reset wr_en", wr_en, 0);
  endtask

  task automatic t_mismatch();
    logic ack;
    int base = log_n;
    bus_start();
    send_byte(8'h7C, ack);
    check("R2 no ack on other address", ack, 0);
    send_byte(8'h83, ack);
    send_byte(8'h05, ack);
    send_byte(8'h11, ack);
    check("R2 ignored data not acked", ack, 0);
    bus_stop(); wt(10);
    check("R2 no writes", log_n, base);
  endtask

  task automatic t_format_a();
    logic ack;
    int base = log_n;
    bus_start();
    send_byte(8'h7A, ack);
    check("R1 address ack", ack, 1);
    send_list("R1 data ack", '{8'h83, 8'h05, 8'h11, 8'hA7, 8'h0C, 8'h22});
    bus_stop(); wt(10);
    check("R8 one strobe per byte (A)", log_n - base, 2);
    expect_wr("R3 R5 bank0 write", base, 1'b0, 4'd3, 5'd5, 8'h11);
    expect_wr("R3 R4 bank1 write", base + 1, 1'b1, 4'd7, 5'd12, 8'h22);
    check("R10 released after stop", sda_oe, 0);
  endtask

  task automatic t_format_b();
    logic ack;
    int base = log_n;
    bus_start();
    send_byte(8'h7A, ack);
    send_list("R6 acks", '{8'h82, 8'h01, 8'h33, 8'h02, 8'h44, 8'h1E, 8'h55,
                           8'hC5, 8'h03, 8'h66});
    bus_stop(); wt(10);
    check("R6 count", log_n - base, 4);
    expect_wr("R6 col 1", base, 1'b0, 4'd2, 5'd1, 8'h33);
    expect_wr("R6 col 2", base + 1, 1'b0, 4'd2, 5'd2, 8'h44);
    expect_wr("R6 col 30", base + 2, 1'b0, 4'd2, 5'd30, 8'h55);
    expect_wr("R3 prefix 110 ignored", base + 3, 1'b0, 4'd2, 5'd3, 8'h66);
  endtask

  task automatic t_format_c();
    logic ack;
    int base = log_n;
    bus_start();
    send_byte(8'h7A, ack);
    send_list("R7 acks", '{8'hA4, 8'h3C, 8'h01, 8'h9F, 8'h02, 8'h03});
    bus_stop(); wt(10);
    check("R7 count", log_n - base, 4);
    expect_wr("R7 col 28", base, 1'b1, 4'd4, 5'd28, 8'h01);
    expect_wr("R7 row-like byte is data", base + 1, 1'b1, 4'd4, 5'd29, 8'h9F);
    expect_wr("R7 col 30", base + 2, 1'b1, 4'd4, 5'd30, 8'h02);
    expect_wr("R7 wrap to 0", base + 3, 1'b1, 4'd4, 5'd0, 8'h03);
  endtask

  task automatic t_restart_mode();
    logic ack;
    int base = log_n;
    bus_start();
    send_byte(8'h7A, ack);
    send_list("R11 acks", '{8'hA1, 8'h22, 8'h0A});
    bus_start();
    send_byte(8'h7A, ack);
    send_list("R11 acks 2", '{8'h81, 8'h02, 8'h77});
    bus_stop(); wt(10);
    check("R11 count", log_n - base, 2);
    expect_wr("R11 burst write", base, 1'b1, 4'd1, 5'd2, 8'h0A);
    expect_wr("R11 row expected after START", base + 1, 1'b0, 4'd1, 5'd2, 8'h77);
  endtask

  task automatic t_read();
    logic ack;
    logic [7:0] b;
    int base = log_n;
    bus_start();
    send_byte(8'h7A, ack);
    send_list("R9 pointer acks", '{8'hA6, 8'h09});
    bus_start();
    send_byte(8'h7B, ack);
    check("R9 read address ack", ack, 1);
    read_byte(b);
    bus_stop(); wt(10);
    check("R9 pointer", {rd_bank, rd_row, rd_col}, {1'b1, 4'd6, 5'd9});
    check("R9 read data", b, mem_val(1'b1, 4'd6, 5'd9));
    check("R9 no write in read", log_n - base, 0);
    check("R10 released after read", sda_oe, 0);
  endtask

  initial begin
    wt(5);
    rst = 1'b0;
    wt(5);
    t_reset();
    t_mismatch();
    t_format_a();
    t_format_b();
    t_format_c();
    t_restart_mode();
    t_read();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule